// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block decides which input-multiplexer channel a successive-approximation converter samples next during a burst of conversions. The burst is started by one command. A start strobe carries a two-bit scan-mode code and a channel number N. The sequencer then issues one start-conversion pulse per channel, with the channel select alongside it. It waits for the converter core to report each conversion done. When the last conversion of the burst has completed, it raises an end-of-conversion flag.

Four orderings are supported:
- a single conversion of channel N;
- an ascending sweep from channel 0 up to N;
- an ascending sweep from channel 4 up to N;
- eight back-to-back conversions of channel N.

Combinations that cannot be run are refused with an error flag and produce no conversion. These are a sweep from channel 4 with N below 4, and any scanning mode requested while the frame-synchronised (DSP) transfer mode is active.

Top module: `scan_sequencer`

## Requirements
- R1: Mode code 0 issues exactly one start pulse, with the channel select equal to N.
- R2: Mode code 1 issues start pulses for channels 0, 1, ..., N in ascending order, for any N from 0 to 7.
- R3: Mode code 2 with N from 4 to 7 issues start pulses for channels 4, 5, ..., N in ascending order.
- R4: Mode code 3 issues eight start pulses, each with the channel select equal to N.
- R5: Mode code 2 with N below 4 sets the error flag in the cycle after the start strobe. It issues no start pulse and leaves end-of-conversion low.
- R6: While the frame-mode input is high, a start strobe with mode code 1, 2 or 3 sets the error flag and issues no start pulse. Mode code 0 is still accepted in that case.
- R7: After a conversion-done strobe that is not the last of the burst, the next start pulse is high in the cycle right after the strobe was sampled. The first start pulse follows an accepted start strobe in the same way.
- R8: End-of-conversion rises in the cycle after the burst's final conversion-done strobe. It stays high until the next start strobe taken while idle, which clears it.
- R9: A start strobe that arrives while a burst is running is ignored. The sequence, the channel select and the flags are unchanged by it.
- R10: After reset, the start pulse, end-of-conversion and error outputs are low, and the channel select is 0.
- R11: A start pulse lasts exactly one cycle.
- R12: A conversion-done strobe is ignored while idle and during a start-pulse cycle. It causes no pulse, no flag change and no advance.
- R13: The error flag is cleared by the next start strobe that requests a valid burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle command strobe that starts a burst |
| mode_i | input | 2 | Scan-mode code: 0 single, 1 sweep from 0, 2 sweep from 4, 3 repeat eight times |
| chan_i | input | 3 | Channel number N |
| frame_mode_i | input | 1 | High while the frame-synchronised transfer mode is active |
| conv_done_i | input | 1 | One-cycle strobe from the converter core when a conversion finishes |
| chan_o | output | 3 | Channel select for the multiplexer |
| conv_start_o | output | 1 | One-cycle pulse that starts a conversion on chan_o |
| eoc_o | output | 1 | High once the whole burst has completed |
| err_o | output | 1 | High after a refused command |

## Verification
On every cycle, the embedded properties check several cycle-to-cycle rules:
- the start pulse lasts one cycle, and a non-final done strobe yields a pulse in the next cycle;
- end-of-conversion is held until a start strobe arrives;
- the channel select does not move while a conversion is outstanding;
- an idle sequencer with no strobe stays quiet;
- a refused frame-mode request never starts a conversion.

Only the bench's scenarios can show that the burst as a whole is right: the ordering and length of each mode's channel list, the boundary values of N, and the effect of strobes injected at awkward moments. The bench checks these by comparing every cycle against a queue-based model of the expected channel list.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE    = 2'd0,
        MODE_LOW_SWEEP = 2'd1,
        MODE_HIGH_SWEEP= 2'd2,
        MODE_REPEAT    = 2'd3
    } scan_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/scan_plan.sv
// Decodes a command into the burst plan: validity, first channel,
// number of conversions still to come after the first, and whether the
// channel advances between conversions.
module scan_plan
    import scan_seq_pkg::*;
#(
    parameter int CH_W      = 3,
    parameter int CNT_W     = 3,
    parameter int REPEAT    = 8,
    parameter int HIGH_BASE = 4
) (
    input  scan_mode_e          mode_i,
    input  logic [CH_W-1:0]     chan_i,
    input  logic                frame_i,
    output logic                bad_o,
    output logic [CH_W-1:0]     first_o,
    output logic [CNT_W-1:0]    count_o,
    output logic                step_o
);

    logic below_base;
    assign below_base = (int'(chan_i) < HIGH_BASE);

    always_comb begin
        bad_o   = 1'b0;
        first_o = chan_i;
        count_o = '0;
        step_o  = 1'b0;
        unique case (mode_i)
            MODE_SINGLE: begin
                first_o = chan_i;
            end
            MODE_LOW_SWEEP: begin
                first_o = '0;
                count_o = CNT_W'(chan_i);
                step_o  = 1'b1;
            end
            MODE_HIGH_SWEEP: begin
                first_o = CH_W'(HIGH_BASE);
                count_o = CNT_W'(chan_i) - CNT_W'(HIGH_BASE);
                step_o  = 1'b1;
                bad_o   = below_base;
            end
            MODE_REPEAT: begin
                first_o = chan_i;
                count_o = CNT_W'(REPEAT - 1);
            end
            default: bad_o = 1'b1;
        endcase
        if (frame_i && (mode_i != MODE_SINGLE)) begin
            bad_o = 1'b1;
        end
    end

endmodule

// File: rtl/scan_step.sv
// Computes the channel and remaining count for the next conversion.
module scan_step #(
    parameter int CH_W  = 3,
    parameter int CNT_W = 3
) (
    input  logic [CH_W-1:0]  chan_i,
    input  logic [CNT_W-1:0] rem_i,
    input  logic             step_i,
    output logic [CH_W-1:0]  chan_o,
    output logic [CNT_W-1:0] rem_o,
    output logic             last_o
);

    assign last_o = (rem_i == '0);
    assign rem_o  = rem_i - CNT_W'(1);
    assign chan_o = step_i ? chan_i + CH_W'(1) : chan_i;

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import scan_seq_pkg::*;
#(
    parameter int CH_W      = 3,
    parameter int REPEAT    = 8,
    parameter int HIGH_BASE = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      mode_i,
    input  logic [CH_W-1:0] chan_i,
    input  logic            frame_mode_i,
    input  logic            conv_done_i,
    output logic [CH_W-1:0] chan_o,
    output logic            conv_start_o,
    output logic            eoc_o,
    output logic            err_o
);

    localparam int NUM_CH  = 1 << CH_W;
    localparam int MAX_CNT = (REPEAT > NUM_CH) ? REPEAT : NUM_CH;
    localparam int CNT_W   = (MAX_CNT > 2) ? $clog2(MAX_CNT) : 1;

    typedef struct packed {
        seq_state_e       state;
        logic [CH_W-1:0]  chan;
        logic [CNT_W-1:0] rem;
        logic             step;
        logic             start;
        logic             eoc;
        logic             err;
    } seq_regs_t;

    seq_regs_t q, d;

    logic             plan_bad;
    logic [CH_W-1:0]  plan_first;
    logic [CNT_W-1:0] plan_count;
    logic             plan_step;

    scan_plan #(
        .CH_W      (CH_W),
        .CNT_W     (CNT_W),
        .REPEAT    (REPEAT),
        .HIGH_BASE (HIGH_BASE)
    ) u_plan (
        .mode_i  (scan_mode_e'(mode_i)),
        .chan_i  (chan_i),
        .frame_i (frame_mode_i),
        .bad_o   (plan_bad),
        .first_o (plan_first),
        .count_o (plan_count),
        .step_o  (plan_step)
    );

    logic [CH_W-1:0]  nxt_chan;
    logic [CNT_W-1:0] nxt_rem;
    logic             is_last;

    scan_step #(
        .CH_W  (CH_W),
        .CNT_W (CNT_W)
    ) u_step (
        .chan_i (q.chan),
        .rem_i  (q.rem),
        .step_i (q.step),
        .chan_o (nxt_chan),
        .rem_o  (nxt_rem),
        .last_o (is_last)
    );

    logic done_take;
    assign done_take = (q.state == ST_RUN) && !q.start && conv_done_i;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.eoc = 1'b0;
                    d.err = plan_bad;
                    if (!plan_bad) begin
                        d.state = ST_RUN;
                        d.chan  = plan_first;
                        d.rem   = plan_count;
                        d.step  = plan_step;
                        d.start = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (done_take) begin
                    if (is_last) begin
                        d.state = ST_IDLE;
                        d.eoc   = 1'b1;
                    end else begin
                        d.chan  = nxt_chan;
                        d.rem   = nxt_rem;
                        d.start = 1'b1;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, chan: '0, rem: '0, step: 1'b0,
                   start: 1'b0, eoc: 1'b0, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign chan_o       = q.chan;
    assign conv_start_o = q.start;
    assign eoc_o        = q.eoc;
    assign err_o        = q.err;

    // R11: start pulses never run into a second cycle
    assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);

    // R7: a non-final done strobe brings the next pulse one cycle later
    assert_next_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RUN && !conv_start_o && conv_done_i && q.rem != '0)
        |=> conv_start_o);

    // R8: end-of-conversion holds until a start strobe
    assert_eoc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_o && !start_i) |=> eoc_o);

    // R9: channel select steady while a conversion is outstanding
    assert_chan_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RUN && !conv_done_i) |=> $stable(chan_o));

    // R12: an idle sequencer with no command stays quiet
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && !start_i) |=> (!conv_start_o && $stable(eoc_o)));

    // R6: a scanning request in frame mode is refused
    assert_frame_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && start_i && frame_mode_i && mode_i != 2'd0)
        |=> (err_o && !conv_start_o));

    // R5: an error flag never rises together with a conversion start
    assert_err_no_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> !conv_start_o);

endmodule

// File: tb/scan_sequencer_tb.sv
module scan_sequencer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic [2:0] chan_i = 3'd0;
    logic       frame_mode_i = 1'b0;
    logic       resp_done = 1'b0;
    logic       stray_done = 1'b0;
    logic       conv_done_i;
    logic [2:0] chan_o;
    logic       conv_start_o;
    logic       eoc_o;
    logic       err_o;

    assign conv_done_i = resp_done | stray_done;

    always #10 clk = ~clk;   // 50 MHz

    scan_sequencer u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .mode_i       (mode_i),
        .chan_i       (chan_i),
        .frame_mode_i (frame_mode_i),
        .conv_done_i  (conv_done_i),
        .chan_o       (chan_o),
        .conv_start_o (conv_start_o),
        .eoc_o        (eoc_o),
        .err_o        (err_o)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R10";
    int    pulses_seen = 0;

    // ---------------- reference model ----------------
    int   exp_q[$];
    bit   m_busy = 0;
    bit   m_start = 0;
    int   m_chan = 0;
    bit   m_eoc = 0;
    bit   m_err = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_start = 0; m_chan = 0; m_eoc = 0; m_err = 0;
            exp_q.delete();
        end else begin
            bit was_start;
            was_start = m_start;
            m_start = 0;
            if (!m_busy && start_i) begin
                bit bad;
                bad = (frame_mode_i && mode_i != 2'd0) ||
                      (mode_i == 2'd2 && chan_i < 3'd4);
                m_eoc = 0;
                m_err = bad;
                if (!bad) begin
                    exp_q.delete();
                    case (mode_i)
                        2'd0: exp_q.push_back(int'(chan_i));
                        2'd1: for (int c = 0; c <= int'(chan_i); c++) exp_q.push_back(c);
                        2'd2: for (int c = 4; c <= int'(chan_i); c++) exp_q.push_back(c);
                        default: for (int k = 0; k < 8; k++) exp_q.push_back(int'(chan_i));
                    endcase
                    m_chan = exp_q.pop_front();
                    m_start = 1;
                    m_busy = 1;
                end
            end else if (m_busy && !was_start && conv_done_i) begin
                if (exp_q.size() > 0) begin
                    m_chan = exp_q.pop_front();
                    m_start = 1;
                end else begin
                    m_busy = 0;
                    m_eoc = 1;
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_req, int'(conv_start_o), int'(m_start), "conv_start");
            if (m_start) begin
                check(cur_req, int'(chan_o), m_chan, "chan");
                pulses_seen++;
            end
            check(cur_req, int'(eoc_o), int'(m_eoc), "eoc");
            check(cur_req, int'(err_o), int'(m_err), "err");
        end
    end

    // converter core stand-in
    int lat = 3;
    int cd = 0;
    always @(negedge clk) begin
        resp_done = 1'b0;
        if (conv_start_o) cd = lat;
        else if (cd > 0) begin
            cd--;
            if (cd == 0) resp_done = 1'b1;
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic command(input logic [1:0] m, input logic [2:0] n, input logic fr,
                           input bit poke_pulse);
        @(negedge clk);
        mode_i = m; chan_i = n; frame_mode_i = fr; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke_pulse) stray_done = 1'b1;   // lands on the start-pulse cycle
        @(negedge clk);
        stray_done = 1'b0;
    endtask

    task automatic finish_burst();
        while (m_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic burst(input string req, input logic [1:0] m, input logic [2:0] n,
                         input logic fr, input int expect_pulses);
        cur_req = req;
        pulses_seen = 0;
        command(m, n, fr, 1'b0);
        finish_burst();
        check(req, pulses_seen, expect_pulses, "pulse count");
    endtask

    initial begin
        // R10: reset values
        repeat (3) @(negedge clk);
        check("R10", int'(conv_start_o), 0, "reset start");
        check("R10", int'(eoc_o), 0, "reset eoc");
        check("R10", int'(err_o), 0, "reset err");
        check("R10", int'(chan_o), 0, "reset chan");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        burst("R1", 2'd0, 3'd5, 1'b0, 1);
        check("R8", int'(eoc_o), 1, "eoc after single");
        burst("R1", 2'd0, 3'd2, 1'b1, 1);      // single allowed in frame mode (R6)
        lat = 1;
        burst("R2", 2'd1, 3'd7, 1'b0, 8);
        burst("R2", 2'd1, 3'd0, 1'b0, 1);
        lat = 5;
        burst("R3", 2'd2, 3'd7, 1'b0, 4);
        burst("R3", 2'd2, 3'd4, 1'b0, 1);
        lat = 2;
        burst("R4", 2'd3, 3'd6, 1'b0, 8);

        // R5: sweep from 4 with N below 4
        burst("R5", 2'd2, 3'd3, 1'b0, 0);
        check("R5", int'(err_o), 1, "err set");
        check("R5", int'(eoc_o), 0, "eoc low");
        // R13: a valid command clears the error
        burst("R13", 2'd1, 3'd1, 1'b0, 2);
        check("R13", int'(err_o), 0, "err cleared");

        // R6: scanning modes refused in frame mode
        burst("R6", 2'd1, 3'd3, 1'b1, 0);
        check("R6", int'(err_o), 1, "err frame sweep");
        burst("R6", 2'd3, 3'd3, 1'b1, 0);
        burst("R6", 2'd2, 3'd6, 1'b1, 0);

        // R9: start strobe during a running burst
        cur_req = "R9";
        lat = 6;
        pulses_seen = 0;
        command(2'd1, 3'd3, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        mode_i = 2'd2; chan_i = 3'd2; start_i = 1'b1;  // would be an error if taken
        @(negedge clk);
        start_i = 1'b0;
        finish_burst();
        check("R9", pulses_seen, 4, "pulse count with extra strobe");
        check("R9", int'(err_o), 0, "err untouched");

        // R12: done strobes while idle and on the pulse cycle
        cur_req = "R12";
        stray_done = 1'b1;
        @(negedge clk);
        stray_done = 1'b0;
        repeat (2) @(negedge clk);
        check("R12", int'(eoc_o), 1, "eoc after idle done");
        pulses_seen = 0;
        lat = 3;
        command(2'd1, 3'd2, 1'b0, 1'b1);
        finish_burst();
        check("R12", pulses_seen, 3, "pulse-cycle done ignored");

        // R7/R11: fastest core response, back-to-back pulses spaced
        lat = 1;
        burst("R7", 2'd3, 3'd1, 1'b0, 8);
        burst("R11", 2'd1, 3'd5, 1'b0, 6);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule